// File: doc/BRIEF.md
# Integer ALU and Branch-Likely Sequencer

This block is the execute and next-PC stage for a small subset of a 32-bit RISC instruction set with branch delay slots. It receives one instruction per clock: the 32-bit instruction word, the values of its two source registers and the instruction's PC. Within the same cycle it produces:

- the computed value and the destination register index;
- a write enable;
- an overflow-trap flag and a reserved-instruction flag;
- the address of the next instruction to fetch.

A status bit shows when the current instruction is a delay slot.

The supported operations are register add with trap and without trap, immediate add with trap and without trap, register AND, immediate AND, branch-if-equal and the "likely" branch-if-equal. Any branch is followed by one delay-slot instruction, and the branch target applies only after that slot. A likely branch that is not taken cancels its slot: the fetch address jumps over it.

Top module: `alu_branch_seq`

## Requirements
- R1: Opcode 000000 with bits [10:6] zero and function 100000 adds the two register values into rd [15:11]. On signed 32-bit overflow, ovf_trap_o is high and the write is suppressed. Opcode 001000 does the same with the sign-extended immediate [15:0], writing rt [20:16].
- R2: Function 100001 under opcode 000000 and opcode 001001 add without trapping. The sum wraps modulo 2^32 and ovf_trap_o stays low. The immediate is sign-extended.
- R3: Function 100100 under opcode 000000 ANDs the two register values. Opcode 001100 ANDs rs with the zero-extended immediate.
- R4: Opcode 000000 with any other function code, or with bits [10:6] non-zero, raises rsvd_o and suppresses the write.
- R5: wr_en_o is never high when the destination index is 0.
- R6: For branch-if-equal (opcode 000100), next_pc_o is pc+4. The following instruction is a delay slot.
- R7: While a delay slot executes, in_slot_o is high. next_pc_o is the branch target (delay-slot address plus the sign-extended offset shifted left by 2) if the branch was taken, else pc+4. A delay slot is never followed by another delay slot.
- R8: A branch-if-equal-likely (opcode 010100) whose operands differ gives next_pc_o = pc+8. No delay slot follows it.
- R9: A taken branch-if-equal-likely behaves as a taken branch-if-equal.
- R10: Branches never write a register. A branch that sits in a delay slot has no effect on sequencing.
- R11: After reset, no delay slot is pending and in_slot_o is low.
- R12: Any other primary opcode writes nothing, raises no flag and gives next_pc_o = pc+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of instr_i |
| rs_val_i | input | 32 | Value of register rs |
| rt_val_i | input | 32 | Value of register rt |
| result_o | output | 32 | Computed value |
| dest_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Register write enable |
| ovf_trap_o | output | 1 | Signed overflow trap on trapping adds |
| rsvd_o | output | 1 | Reserved instruction flag |
| next_pc_o | output | 32 | Next fetch address |
| in_slot_o | output | 1 | Current instruction is a delay slot |

## Verification
An overflow trap and a branch redirect can occur in the same cycle when the delay slot of a taken branch is a trapping add that overflows. The bench places such an add in the slot of a taken branch. It then expects ovf_trap_o high, wr_en_o low, in_slot_o high and next_pc_o equal to the branch target, all in that one cycle. It also places a reserved instruction in a not-taken slot, so the reserved flag coincides with a sequential slot exit.

// File: rtl/alu_seq_pkg.sv
package alu_seq_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_ADDU, OP_AND, OP_ADDI, OP_ADDIU, OP_ANDI,
    OP_BEQ, OP_BEQL, OP_RSVD
  } op_e;

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_ADDI  = 6'b001000;
  localparam logic [5:0] OPC_ADDIU = 6'b001001;
  localparam logic [5:0] OPC_ANDI  = 6'b001100;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_BEQL  = 6'b010100;

  localparam logic [5:0] FN_ADD  = 6'b100000;
  localparam logic [5:0] FN_ADDU = 6'b100001;
  localparam logic [5:0] FN_AND  = 6'b100100;

  function automatic logic op_is_branch(op_e op);
    return (op == OP_BEQ) || (op == OP_BEQL);
  endfunction
endpackage

// File: rtl/alu_seq_decode.sv
module alu_seq_decode
  import alu_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RIDX_W = 5
) (
  input  logic [31:0]        instr_i,
  output op_e                op_o,
  output logic [RIDX_W-1:0]  dest_o,
  output logic [DATA_W-1:0]  imm_ext_o
);
  localparam int IMM_W = 16;

  logic [5:0]       opc, fn;
  logic [4:0]       shamt;
  logic [IMM_W-1:0] imm;
  logic             zext;

  assign opc   = instr_i[31:26];
  assign fn    = instr_i[5:0];
  assign shamt = instr_i[10:6];
  assign imm   = instr_i[15:0];

  always_comb begin
    op_o   = OP_NONE;
    dest_o = instr_i[16 +: RIDX_W];
    zext   = 1'b0;
    unique case (opc)
      OPC_REG: begin
        dest_o = instr_i[11 +: RIDX_W];
        if (shamt != '0) op_o = OP_RSVD;
        else begin
          unique case (fn)
            FN_ADD:  op_o = OP_ADD;
            FN_ADDU: op_o = OP_ADDU;
            FN_AND:  op_o = OP_AND;
            default: op_o = OP_RSVD;
          endcase
        end
      end
      OPC_ADDI:  op_o = OP_ADDI;
      OPC_ADDIU: op_o = OP_ADDIU;
      OPC_ANDI: begin
        op_o = OP_ANDI;
        zext = 1'b1;
      end
      OPC_BEQ:   op_o = OP_BEQ;
      OPC_BEQL:  op_o = OP_BEQL;
      default:   op_o = OP_NONE;
    endcase
  end

  generate
    if (DATA_W > IMM_W) begin : g_ext
      assign imm_ext_o = zext ? {{(DATA_W-IMM_W){1'b0}}, imm}
                              : {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign imm_ext_o = imm[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/alu_seq_exec.sv
module alu_seq_exec
  import alu_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              writes_o,
  output logic              ovf_trap_o,
  output logic              rsvd_o,
  output logic              eq_o
);
  localparam int MSB = DATA_W - 1;

  logic              use_imm, is_and, traps, ovf;
  logic [DATA_W-1:0] opb, sum;

  always_comb begin
    use_imm  = (op_i == OP_ADDI) || (op_i == OP_ADDIU) || (op_i == OP_ANDI);
    is_and   = (op_i == OP_AND)  || (op_i == OP_ANDI);
    traps    = (op_i == OP_ADD)  || (op_i == OP_ADDI);
    writes_o = (op_i == OP_ADD)  || (op_i == OP_ADDU) || (op_i == OP_AND) ||
               use_imm;
    opb      = use_imm ? imm_i : b_i;
    sum      = a_i + opb;
    // signed overflow: like-signed operands, result sign differs
    ovf      = (a_i[MSB] == opb[MSB]) && (sum[MSB] != a_i[MSB]);
    result_o = is_and ? (a_i & opb) : sum;
  end

  assign ovf_trap_o = traps & ovf;
  assign rsvd_o     = (op_i == OP_RSVD);
  assign eq_o       = (a_i == b_i);
endmodule

// File: rtl/alu_seq_pcseq.sv
module alu_seq_pcseq
  import alu_seq_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic              eq_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] imm_ext_i,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              in_slot_o
);
  localparam logic [PC_W-1:0] STEP  = PC_W'(4);
  localparam logic [PC_W-1:0] SKIP2 = PC_W'(8);

  logic            slot_q, take_q;
  logic [PC_W-1:0] tgt_q;
  logic            br, take, skip, slot_d;
  logic [PC_W-1:0] seq_pc, tgt_d;

  always_comb begin
    seq_pc = pc_i + STEP;
    // branches in a slot are ignored for sequencing
    br     = op_is_branch(op_i) && !slot_q;
    take   = br && eq_i;
    skip   = br && (op_i == OP_BEQL) && !eq_i;
    slot_d = br && !skip;
    tgt_d  = seq_pc + PC_W'({imm_ext_i, 2'b00});
    if (slot_q)    next_pc_o = take_q ? tgt_q : seq_pc;
    else if (skip) next_pc_o = pc_i + SKIP2;
    else           next_pc_o = seq_pc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= 1'b0;
      take_q <= 1'b0;
      tgt_q  <= '0;
    end else begin
      slot_q <= slot_d;
      take_q <= take;
      if (br) tgt_q <= tgt_d;
    end
  end

  assign in_slot_o = slot_q;
endmodule

// File: rtl/alu_branch_seq.sv
module alu_branch_seq
  import alu_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int RIDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       instr_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  output logic [DATA_W-1:0] result_o,
  output logic [RIDX_W-1:0] dest_o,
  output logic              wr_en_o,
  output logic              ovf_trap_o,
  output logic              rsvd_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              in_slot_o
);
  op_e               op;
  logic [DATA_W-1:0] imm_ext;
  logic              writes, eq;

  alu_seq_decode #(.DATA_W(DATA_W), .RIDX_W(RIDX_W)) u_dec (
    .instr_i   (instr_i),
    .op_o      (op),
    .dest_o    (dest_o),
    .imm_ext_o (imm_ext)
  );

  alu_seq_exec #(.DATA_W(DATA_W)) u_exec (
    .op_i       (op),
    .a_i        (rs_val_i),
    .b_i        (rt_val_i),
    .imm_i      (imm_ext),
    .result_o   (result_o),
    .writes_o   (writes),
    .ovf_trap_o (ovf_trap_o),
    .rsvd_o     (rsvd_o),
    .eq_o       (eq)
  );

  alu_seq_pcseq #(.PC_W(PC_W), .DATA_W(DATA_W)) u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .eq_i      (eq),
    .pc_i      (pc_i),
    .imm_ext_i (imm_ext),
    .next_pc_o (next_pc_o),
    .in_slot_o (in_slot_o)
  );

  assign wr_en_o = writes && !ovf_trap_o && !rsvd_o && (dest_o != '0);
endmodule

// File: rtl/alu_seq_checker.sv
module alu_seq_checker #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int RIDX_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [31:0]       instr_i,
  input logic [PC_W-1:0]   pc_i,
  input logic [DATA_W-1:0] rs_val_i,
  input logic [DATA_W-1:0] rt_val_i,
  input logic [RIDX_W-1:0] dest_o,
  input logic              wr_en_o,
  input logic              ovf_trap_o,
  input logic              rsvd_o,
  input logic [PC_W-1:0]   next_pc_o,
  input logic              in_slot_o
);
  logic is_beq, is_beql;
  assign is_beq  = (instr_i[31:26] == 6'b000100);
  assign is_beql = (instr_i[31:26] == 6'b010100);

  assert_no_zero_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (dest_o != '0));

  assert_trap_blocks_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_trap_o |-> !wr_en_o);

  assert_rsvd_blocks_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_o |-> !wr_en_o);

  assert_branch_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_beq || is_beql) |-> !wr_en_o);

  assert_slot_follows_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_beq && !in_slot_o) |=> in_slot_o);

  assert_single_slot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_slot_o |=> !in_slot_o);

  assert_likely_skip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_beql && !in_slot_o && (rs_val_i != rt_val_i)) |->
      (next_pc_o == pc_i + PC_W'(8)));

  assert_likely_no_slot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_beql && !in_slot_o && (rs_val_i != rt_val_i)) |=> !in_slot_o);
endmodule

bind alu_branch_seq alu_seq_checker #(.DATA_W(DATA_W), .PC_W(PC_W), .RIDX_W(RIDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .instr_i    (instr_i),
  .pc_i       (pc_i),
  .rs_val_i   (rs_val_i),
  .rt_val_i   (rt_val_i),
  .dest_o     (dest_o),
  .wr_en_o    (wr_en_o),
  .ovf_trap_o (ovf_trap_o),
  .rsvd_o     (rsvd_o),
  .next_pc_o  (next_pc_o),
  .in_slot_o  (in_slot_o)
);

// File: tb/alu_branch_seq_bench.sv
module alu_branch_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr_i = 32'h8c00_0000;
  logic [31:0] pc_i = 32'h100;
  logic [31:0] rs_val_i = '0, rt_val_i = '0;
  logic [31:0] result_o, next_pc_o;
  logic [4:0]  dest_o;
  logic        wr_en_o, ovf_trap_o, rsvd_o, in_slot_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  bit          m_slot = 0, m_take = 0;
  logic [31:0] m_tgt = '0, m_pc = 32'h100;

  always #2 clk_i = ~clk_i;

  alu_branch_seq u_alu_branch_seq (.*);

  function automatic logic [31:0] rtype(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'b0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction
  function automatic logic [31:0] itype(logic [5:0] opc, int rs, int rt, logic [15:0] imm);
    return {opc, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [31:0] ins, logic [31:0] a, logic [31:0] b);
    logic [5:0] opc, fn;
    logic [31:0] imm_s, imm_z, e_res, e_npc;
    logic [4:0] e_dst;
    bit e_w, e_ovf, e_rsv, alu, brn, likely, eq;
    longint s;
    @(posedge clk_i);
    #1;
    instr_i = ins; rs_val_i = a; rt_val_i = b; pc_i = m_pc;
    #1;
    opc = ins[31:26]; fn = ins[5:0];
    imm_s = {{16{ins[15]}}, ins[15:0]};
    imm_z = {16'h0, ins[15:0]};
    e_res = '0; e_dst = ins[20:16]; e_ovf = 0; e_rsv = 0; alu = 0; brn = 0; likely = 0;
    eq = (a == b);
    if (opc == 6'b000000) begin
      e_dst = ins[15:11];
      if (ins[10:6] != 0) e_rsv = 1;
      else if (fn == 6'b100000 || fn == 6'b100001) begin
        alu = 1;
        s = longint'($signed(a)) + longint'($signed(b));
        e_res = a + b;
        e_ovf = (fn == 6'b100000) && (s > 64'sd2147483647 || s < -64'sd2147483648);
      end else if (fn == 6'b100100) begin
        alu = 1; e_res = a & b;
      end else e_rsv = 1;
    end else if (opc == 6'b001000 || opc == 6'b001001) begin
      alu = 1;
      s = longint'($signed(a)) + longint'($signed(imm_s));
      e_res = a + imm_s;
      e_ovf = (opc == 6'b001000) && (s > 64'sd2147483647 || s < -64'sd2147483648);
    end else if (opc == 6'b001100) begin
      alu = 1; e_res = a & imm_z;
    end else if (opc == 6'b000100 || opc == 6'b010100) begin
      brn = !m_slot; likely = (opc == 6'b010100);
    end
    e_w = alu && !e_ovf && !e_rsv && (e_dst != 0);
    if (m_slot)                    e_npc = m_take ? m_tgt : m_pc + 4;
    else if (brn && likely && !eq) e_npc = m_pc + 8;
    else                           e_npc = m_pc + 4;

    chk(tag, "wr_en", 32'(wr_en_o), 32'(e_w));
    chk(tag, "ovf", 32'(ovf_trap_o), 32'(e_ovf));
    chk(tag, "rsvd", 32'(rsvd_o), 32'(e_rsv));
    chk(tag, "next_pc", next_pc_o, e_npc);
    chk(tag, "in_slot", 32'(in_slot_o), 32'(m_slot));
    if (alu) begin
      chk(tag, "result", result_o, e_res);
      chk(tag, "dest", 32'(dest_o), 32'(e_dst));
    end

    // advance model
    if (brn) begin
      m_slot = !(likely && !eq);
      m_take = eq;
      m_tgt  = m_pc + 4 + (imm_s << 2);
    end else begin
      m_slot = 0; m_take = 0;
    end
    m_pc = e_npc;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R11", "in_slot reset", 32'(in_slot_o), 32'd0);
    rst_ni = 1'b1;
    chk("R11", "in_slot after reset", 32'(in_slot_o), 32'd0);

    step("R1", rtype(1, 2, 3, 0, 6'b100000), 32'd5, 32'd7);
    step("R1", rtype(1, 2, 3, 0, 6'b100000), 32'h7fff_ffff, 32'd1);
    step("R1", rtype(1, 2, 4, 0, 6'b100000), 32'h8000_0000, 32'hffff_ffff);
    step("R1", itype(6'b001000, 1, 5, 16'hfffe), 32'd10, 32'd0);
    step("R1", itype(6'b001000, 1, 5, 16'h0001), 32'h7fff_ffff, 32'd0);
    step("R2", rtype(1, 2, 6, 0, 6'b100001), 32'h7fff_ffff, 32'd1);
    step("R2", itype(6'b001001, 1, 7, 16'h8000), 32'h8000_0000, 32'd0);
    step("R3", rtype(1, 2, 8, 0, 6'b100100), 32'hf0f0_1234, 32'h0ff0_ffff);
    step("R3", itype(6'b001100, 1, 9, 16'hf0f0), 32'hffff_ffff, 32'd0);
    step("R4", rtype(1, 2, 3, 0, 6'b100010), 32'd1, 32'd2);
    step("R4", rtype(1, 2, 3, 4, 6'b100000), 32'd1, 32'd2);
    step("R5", rtype(1, 2, 0, 0, 6'b100001), 32'd3, 32'd4);
    step("R5", itype(6'b001100, 1, 0, 16'hffff), 32'd3, 32'd0);
    step("R12", itype(6'b100011, 1, 2, 16'h0010), 32'd3, 32'd0);

    // taken branch, overflowing trapping add in its slot
    step("R6", itype(6'b000100, 1, 2, 16'h0004), 32'd9, 32'd9);
    step("R7", rtype(1, 2, 3, 0, 6'b100000), 32'h7fff_ffff, 32'h7fff_ffff);
    step("R7", itype(6'b001001, 1, 2, 16'h0001), 32'd1, 32'd0);
    // not-taken branch, reserved op in slot
    step("R6", itype(6'b000100, 1, 2, 16'h0010), 32'd1, 32'd2);
    step("R7", rtype(1, 2, 3, 0, 6'b111111), 32'd1, 32'd2);
    // likely taken, backwards offset
    step("R9", itype(6'b010100, 1, 2, 16'hfff8), 32'd6, 32'd6);
    step("R9", itype(6'b001001, 1, 2, 16'h0003), 32'd1, 32'd0);
    // likely not taken: slot skipped
    step("R8", itype(6'b010100, 1, 2, 16'h0020), 32'd6, 32'd7);
    step("R8", itype(6'b001001, 1, 2, 16'h0003), 32'd1, 32'd0);
    // branch in slot has no sequencing effect
    step("R10", itype(6'b000100, 1, 2, 16'h0008), 32'd1, 32'd1);
    step("R10", itype(6'b010100, 1, 2, 16'h0040), 32'd1, 32'd2);
    step("R10", itype(6'b001001, 1, 2, 16'h0001), 32'd1, 32'd0);
    step("R10", itype(6'b000100, 1, 2, 16'h0008), 32'd1, 32'd2);
    step("R10", itype(6'b000100, 1, 2, 16'h0008), 32'd4, 32'd4);
    step("R10", itype(6'b001001, 1, 2, 16'h0001), 32'd1, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL all watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule